// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer DMA Controller

This block moves a block of words between a peripheral data port and memory without the processor touching each word. The processor programs three registers over a small register port: the first memory address, the number of words, and a control word that selects the direction and whether completion should raise an interrupt. Setting the start bit launches the transfer.

For every word the controller raises a bus request and waits for the grant. It then drives the memory address and a single read or write strobe for one cycle, and it hands the data across between memory and peripheral in that same cycle. After each word it withdraws the request for at least one cycle, so the arbiter can give the processor its own memory cycles between DMA words. The current address and remaining count advance in place and can be read back at any time. When the count reaches zero the controller sets its done flag and, if interrupts are enabled, an interrupt request flag that drives the `irq` pin. Software clears both by writing one to the done bit.

Top module: `cs_dma`

## Requirements
- R1: After reset, the address, count and control registers read as zero, and `bus_req`, `irq`, `mem_rd`, `mem_wr`, `periph_rd` and `periph_wr` are low.
- R2: Register offset 0 is the memory address, offset 1 the word count, offset 2 the control word. Control bits: bit 0 start (write only, reads 0), bit 1 direction (1 moves peripheral to memory, 0 moves memory to peripheral), bit 2 interrupt enable, bit 3 done (write 1 to clear), bit 4 interrupt request (read only). A control write while idle updates direction and enable even without start.
- R3: For each word the controller asserts `bus_req`, waits for `bus_gnt`, then asserts exactly one strobe for one cycle with `mem_addr` equal to the start address plus the word index modulo 2^ADDR_W, and only while the grant is held.
- R4: Between two consecutive words `bus_req` is low for at least one cycle.
- R5: With direction 1 each word cycle asserts `mem_wr` and `periph_rd` with `mem_wdata` equal to `periph_din`. With direction 0 it asserts `mem_rd` and `periph_wr` with `periph_dout` equal to `mem_rdata`. The two strobes never coincide.
- R6: Each word increments the address register by one and decrements the count register by one. After completion the count reads 0 and the address reads the start address plus the word count.
- R7: The cycle after the last word, done is set. The interrupt request flag and the `irq` pin are set together with done only if interrupt enable is 1.
- R8: Start with a count of zero sets done in the next cycle, with no bus request and no strobe.
- R9: Writing 1 to the done bit clears done and the interrupt request. A start clears both before the new transfer.
- R10: While a transfer is in progress, writes to the address and count registers and control writes, including a new start, are ignored, except for the done clear.
- R11: If a done clear is written in the same cycle in which completion sets done, done and the interrupt request end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 1 | Register port select |
| cpu_wr | input | 1 | Register write when selected |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data for the offset on `cpu_addr` |
| bus_req | output | 1 | Bus request for one word |
| bus_gnt | input | 1 | Bus grant, held by the arbiter while the request stays high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the strobe cycle |
| periph_din | input | DATA_W | Word offered by the peripheral |
| periph_rd | output | 1 | Peripheral word consumed |
| periph_dout | output | DATA_W | Word handed to the peripheral |
| periph_wr | output | 1 | Peripheral word delivered |
| irq | output | 1 | Interrupt request |

## Verification
The case that needs care is a software clear of the done bit in the same cycle as the hardware completion of the last word. The bench waits until it sees the final word's strobe, then drives the clear so that both land on the same clock edge. It judges the result by reading back done and the interrupt flag, which must both stay set. A sweep over direction, interrupt enable, word counts including zero, an address range that wraps, and two grant latencies checks every strobe cycle against arithmetic expectations for address and data.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

  localparam int unsigned REG_OFS_W = 2;

  localparam logic [REG_OFS_W-1:0] OFS_ADDR  = 2'd0;
  localparam logic [REG_OFS_W-1:0] OFS_COUNT = 2'd1;
  localparam logic [REG_OFS_W-1:0] OFS_CTRL  = 2'd2;

  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_DIR   = 1;
  localparam int unsigned CB_IE    = 2;
  localparam int unsigned CB_DONE  = 3;
  localparam int unsigned CB_IRQ   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } eng_state_e;

endpackage

// File: rtl/cs_dma_rst_sync.sv
module cs_dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_sel,
  input  logic                 cpu_wr,
  input  logic [REG_OFS_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  input  logic                 busy,
  input  logic                 step,
  input  logic                 eng_done,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic                 last_word,
  output logic                 dir,
  output logic                 go,
  output logic                 irq
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dir_q, dir_d;
  logic              ie_q, ie_d;
  logic              done_q, done_d;
  logic              irq_q, irq_d;

  logic wr_any, wr_addr, wr_cnt, wr_ctrl, wr_ctrl_idle;
  logic start_req, cnt_zero, zero_start, done_clr, done_set;
  logic addr_en, cnt_en, mode_en, flag_en;
  logic unused_wdata;

  assign unused_wdata = ^cpu_wdata;

  // Decode of the register port; address, count and mode are locked while busy.
  assign wr_any       = cpu_sel & cpu_wr;
  assign wr_addr      = wr_any & (cpu_addr == OFS_ADDR) & ~busy;
  assign wr_cnt       = wr_any & (cpu_addr == OFS_COUNT) & ~busy;
  assign wr_ctrl      = wr_any & (cpu_addr == OFS_CTRL);
  assign wr_ctrl_idle = wr_ctrl & ~busy;

  assign start_req  = wr_ctrl_idle & cpu_wdata[CB_START];
  assign cnt_zero   = (cnt_q == '0);
  assign go         = start_req & ~cnt_zero;
  assign zero_start = start_req & cnt_zero;
  assign done_clr   = wr_ctrl & cpu_wdata[CB_DONE];
  assign done_set   = eng_done | zero_start;

  // Next-state logic
  always_comb begin
    addr_d = addr_q;
    if (wr_addr) begin
      addr_d = cpu_wdata[ADDR_W-1:0];
    end else if (step) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt) begin
      cnt_d = cpu_wdata[CNT_W-1:0];
    end else if (step) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    dir_d = dir_q;
    ie_d  = ie_q;
    if (wr_ctrl_idle) begin
      dir_d = cpu_wdata[CB_DIR];
      ie_d  = cpu_wdata[CB_IE];
    end
  end

  // A completion in the same cycle as a clear leaves the flags set.
  always_comb begin
    done_d = done_q;
    irq_d  = irq_q;
    if (done_clr || start_req) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
    if (done_set) begin
      done_d = 1'b1;
      irq_d  = ie_d;
    end
  end

  assign addr_en = wr_addr | step;
  assign cnt_en  = wr_cnt | step;
  assign mode_en = wr_ctrl_idle;
  assign flag_en = done_clr | start_req | done_set;

  // Register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (mode_en) begin
      dir_q <= dir_d;
      ie_q  <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (flag_en) begin
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  // Read mux
  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      OFS_ADDR:  cpu_rdata[ADDR_W-1:0] = addr_q;
      OFS_COUNT: cpu_rdata[CNT_W-1:0]  = cnt_q;
      OFS_CTRL: begin
        cpu_rdata[CB_DIR]  = dir_q;
        cpu_rdata[CB_IE]   = ie_q;
        cpu_rdata[CB_DONE] = done_q;
        cpu_rdata[CB_IRQ]  = irq_q;
      end
      default: cpu_rdata = '0;
    endcase
  end

  assign cur_addr  = addr_q;
  assign last_word = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign dir       = dir_q;
  assign irq       = irq_q;

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == $past(addr_q) + 1'b1));

  // R7
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ie_q);

  // R11
  done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_q);

  // R8
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (done_q && !busy));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(dir_q)));

endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
  import cs_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic last_word,
  input  logic bus_gnt,
  output logic bus_req,
  output logic xfer,
  output logic busy,
  output logic eng_done
);

  eng_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_REQ;
      ST_REQ:  if (bus_gnt) state_d = ST_XFER;
      ST_XFER: state_d = last_word ? ST_IDLE : ST_GAP;
      ST_GAP:  state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign bus_req  = (state_q == ST_REQ) | (state_q == ST_XFER);
  assign xfer     = (state_q == ST_XFER);
  assign busy     = (state_q != ST_IDLE);
  assign eng_done = xfer & last_word;

  // R4
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last_word) |=> !bus_req);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);

  // R10
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

endmodule

// File: rtl/cs_dma_steer.sv
module cs_dma_steer #(
  parameter int unsigned DATA_W    = 16,
  parameter bit          GATE_DATA = 1'b1
) (
  input  logic              xfer,
  input  logic              dir,
  input  logic [DATA_W-1:0] periph_din,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              periph_rd,
  output logic              periph_dout_vld,
  output logic [DATA_W-1:0] periph_dout
);

  logic to_mem, from_mem;

  assign to_mem   = xfer & dir;
  assign from_mem = xfer & ~dir;

  assign mem_wr          = to_mem;
  assign periph_rd       = to_mem;
  assign mem_rd          = from_mem;
  assign periph_dout_vld = from_mem;

  generate
    if (GATE_DATA) begin : g_gated
      assign mem_wdata   = to_mem   ? periph_din : '0;
      assign periph_dout = from_mem ? mem_rdata  : '0;
    end else begin : g_open
      assign mem_wdata   = periph_din;
      assign periph_dout = mem_rdata;
    end
  endgenerate

endmodule

// File: rtl/cs_dma.sv
module cs_dma
  import cs_dma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter bit          GATE_DATA = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_sel,
  input  logic                 cpu_wr,
  input  logic [REG_OFS_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 bus_req,
  input  logic                 bus_gnt,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic [DATA_W-1:0]    periph_din,
  output logic                 periph_rd,
  output logic [DATA_W-1:0]    periph_dout,
  output logic                 periph_wr,
  output logic                 irq
);

  logic srst_n;
  logic busy, xfer, eng_done, go, last_word, dir;

  cs_dma_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (srst_n)
  );

  cs_dma_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .busy      (busy),
    .step      (xfer),
    .eng_done  (eng_done),
    .cur_addr  (mem_addr),
    .last_word (last_word),
    .dir       (dir),
    .go        (go),
    .irq       (irq)
  );

  cs_dma_engine u_engine (
    .clk       (clk),
    .rst_n     (srst_n),
    .go        (go),
    .last_word (last_word),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .xfer      (xfer),
    .busy      (busy),
    .eng_done  (eng_done)
  );

  cs_dma_steer #(
    .DATA_W    (DATA_W),
    .GATE_DATA (GATE_DATA)
  ) u_steer (
    .xfer            (xfer),
    .dir             (dir),
    .periph_din      (periph_din),
    .mem_rdata       (mem_rdata),
    .mem_rd          (mem_rd),
    .mem_wr          (mem_wr),
    .mem_wdata       (mem_wdata),
    .periph_rd       (periph_rd),
    .periph_dout_vld (periph_wr),
    .periph_dout     (periph_dout)
  );

  // R3
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(mem_rd && mem_wr));

  // R5
  pair_wr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_wr |-> (periph_rd && !periph_wr));

  // R5
  pair_rd_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mem_rd |-> (periph_wr && !periph_rd));

endmodule

// File: tb/cs_dma_tb.sv
module cs_dma_tb;
  import cs_dma_pkg::*;

  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cpu_sel = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [1:0]    cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] periph_din, periph_dout;
  logic          periph_rd, periph_wr, irq;

  logic [DW-1:0] mem_m [256];
  int            src_idx = 0;

  assign mem_rdata  = mem_m[mem_addr];
  assign periph_din = 16'hC000 + src_idx[15:0];

  cs_dma #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .periph_din(periph_din), .periph_rd(periph_rd),
    .periph_dout(periph_dout), .periph_wr(periph_wr),
    .irq(irq)
  );

  int tests = 0;
  int fails = 0;

  // monitor state
  logic [AW-1:0] cur_base = '0;
  logic          cur_dir = 1'b0;
  int            lat_cfg = 0;
  int            req_age = 0;
  int            mon_strobes = 0;
  int            mon_addr_err = 0;
  int            mon_data_err = 0;
  int            mon_gap_err = 0;
  bit            mon_req_seen = 0;
  bit            need_drop = 0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return 16'(a) * 16'd37 + 16'd5;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bus arbiter, memory and peripheral models, plus per-word checking
  always @(negedge clk) begin
    logic [AW-1:0] exp_a;
    if (rst_n) begin
      if (mem_rd || mem_wr) begin
        exp_a = cur_base + mon_strobes[AW-1:0];
        if (mem_addr !== exp_a) mon_addr_err++;
        if (cur_dir) begin
          if (!(mem_wr && periph_rd && !mem_rd && !periph_wr) ||
              mem_wdata !== (16'hC000 + mon_strobes[15:0])) mon_data_err++;
        end else begin
          if (!(mem_rd && periph_wr && !mem_wr && !periph_rd) ||
              periph_dout !== pat(exp_a)) mon_data_err++;
        end
        if (need_drop) mon_gap_err++;
        need_drop = 1;
        mon_strobes++;
        if (mem_wr) mem_m[mem_addr] = mem_wdata;
        if (periph_rd) src_idx++;
      end else if (periph_rd || periph_wr) begin
        mon_data_err++;
      end
      if (!bus_req) need_drop = 0;
      if (bus_req) mon_req_seen = 1;
      if (bus_req) begin
        if (req_age >= lat_cfg) bus_gnt = 1'b1;
        req_age++;
      end else begin
        bus_gnt = 1'b0;
        req_age = 0;
      end
    end
  end

  task automatic cpu_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [DW-1:0] v);
    cpu_addr = a;
    #1;
    v = cpu_rdata;
  endtask

  task automatic prep(input logic [AW-1:0] base, input logic dir, input int lat);
    for (int i = 0; i < 256; i++) mem_m[i] = pat(i[AW-1:0]);
    src_idx = 0; cur_base = base; cur_dir = dir; lat_cfg = lat;
    mon_strobes = 0; mon_addr_err = 0; mon_data_err = 0; mon_gap_err = 0;
    mon_req_seen = 0; need_drop = 0;
  endtask

  task automatic wait_done(input string tag);
    logic [DW-1:0] v;
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cpu_read(OFS_CTRL, v);
      if (v[CB_DONE]) begin ok = 1; break; end
    end
    check({tag, " R7 done reached"}, int'(ok), 1);
  endtask

  task automatic run_case(input logic dir, input logic ie, input int n,
                          input logic [AW-1:0] base, input int lat);
    logic [DW-1:0] v;
    string tag;
    tag = $sformatf("dir=%0d ie=%0d n=%0d base=%0h lat=%0d", dir, ie, n, base, lat);
    prep(base, dir, lat);
    cpu_write(OFS_ADDR, DW'(base));
    cpu_write(OFS_COUNT, DW'(n));
    mon_req_seen = 0;
    cpu_write(OFS_CTRL, DW'((1 << CB_START) | (int'(dir) << CB_DIR) | (int'(ie) << CB_IE)));
    cpu_read(OFS_CTRL, v);
    if (n == 0) begin
      check({tag, " R8 zero count done next cycle"}, int'(v[CB_DONE]), 1);
      repeat (3) @(negedge clk);
      check({tag, " R8 zero count no request"}, int'(mon_req_seen), 0);
    end else begin
      check({tag, " R9 start clears done"}, int'(v[CB_DONE]), 0);
      wait_done(tag);
    end
    check({tag, " R3 word strobes"}, mon_strobes, n);
    check({tag, " R3 address sequence errors"}, mon_addr_err, 0);
    check({tag, " R5 data path errors"}, mon_data_err, 0);
    check({tag, " R4 request gap errors"}, mon_gap_err, 0);
    cpu_read(OFS_COUNT, v);
    check({tag, " R6 final count"}, int'(v), 0);
    cpu_read(OFS_ADDR, v);
    check({tag, " R6 final address"}, int'(v), int'(AW'(base + AW'(n))));
    cpu_read(OFS_CTRL, v);
    check({tag, " R7 irq flag follows ie"}, int'(v[CB_IRQ]), int'(ie));
    check({tag, " R7 irq pin follows ie"}, int'(irq), int'(ie));
    if ((n % 2) == 1) begin
      cpu_write(OFS_CTRL, DW'(1 << CB_DONE));
      cpu_read(OFS_CTRL, v);
      check({tag, " R9 clear done"}, int'(v[CB_DONE]), 0);
      check({tag, " R9 clear irq"}, int'(v[CB_IRQ]) | int'(irq), 0);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cpu_read(OFS_ADDR, v);  check("R1 address reset", int'(v), 0);
    cpu_read(OFS_COUNT, v); check("R1 count reset", int'(v), 0);
    cpu_read(OFS_CTRL, v);  check("R1 control reset", int'(v), 0);
    check("R1 outputs idle",
          int'({bus_req, irq, mem_rd, mem_wr, periph_rd, periph_wr}), 0);

    // R2 control readback without start
    cpu_write(OFS_CTRL, DW'((1 << CB_DIR) | (1 << CB_IE)));
    cpu_read(OFS_CTRL, v);
    check("R2 control readback", int'(v), (1 << CB_DIR) | (1 << CB_IE));
    cpu_write(OFS_ADDR, 16'h00A7);
    cpu_read(OFS_ADDR, v);
    check("R2 address readback", int'(v), 'hA7);
    check("R2 no request without start", int'(bus_req), 0);

    // sweep
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < 5; k++) begin
          for (int l = 0; l < 2; l++) begin
            int n;
            logic [AW-1:0] b;
            case (k)
              0: n = 0;
              1: n = 1;
              2: n = 2;
              3: n = 3;
              default: n = 6;
            endcase
            b = (n == 6) ? 8'hFD : AW'((d * 2 + e) * 64 + n * 9 + l);
            run_case(d[0], e[0], n, b, l * 2);
          end
        end
      end
    end

    // R10 writes while busy are ignored
    prep(8'h10, 1'b0, 3);
    cpu_write(OFS_ADDR, 16'h0010);
    cpu_write(OFS_COUNT, 16'd4);
    cpu_write(OFS_CTRL, DW'(1 << CB_START));
    cpu_write(OFS_ADDR, 16'h0077);
    cpu_write(OFS_COUNT, 16'h0055);
    cpu_write(OFS_CTRL, DW'((1 << CB_START) | (1 << CB_DIR) | (1 << CB_IE)));
    wait_done("busy");
    check("R10 strobes unchanged by busy writes", mon_strobes, 4);
    check("R10 address sequence under busy writes", mon_addr_err + mon_data_err, 0);
    cpu_read(OFS_ADDR, v);  check("R10 address register", int'(v), 'h14);
    cpu_read(OFS_COUNT, v); check("R10 count register", int'(v), 0);
    cpu_read(OFS_CTRL, v);
    check("R10 control mode kept", int'(v), 1 << CB_DONE);

    // R11 done clear in the completion cycle
    prep(8'h40, 1'b1, 0);
    cpu_write(OFS_ADDR, 16'h0040);
    cpu_write(OFS_COUNT, 16'd2);
    cpu_write(OFS_CTRL, DW'((1 << CB_START) | (1 << CB_DIR) | (1 << CB_IE)));
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        #1;
        if (mem_wr && mon_strobes == 2) begin seen = 1; break; end
      end
      check("R11 last word observed", int'(seen), 1);
    end
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = OFS_CTRL; cpu_wdata = DW'(1 << CB_DONE);
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
    cpu_read(OFS_CTRL, v);
    check("R11 done survives same-cycle clear", int'(v[CB_DONE]), 1);
    check("R11 irq survives same-cycle clear", int'(v[CB_IRQ]), 1);
    check("R5 peripheral words landed", int'(mem_m[8'h41]), 'hC001);
    cpu_write(OFS_CTRL, DW'(1 << CB_DONE));
    cpu_read(OFS_CTRL, v);
    check("R9 later clear takes effect", int'(v[CB_DONE]) | int'(irq), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule